// File: doc/BRIEF.md
# Two-Bank DRAM Controller with Interleaved Refresh

This block sits on a 16-bit processor bus that uses an address strobe and separate upper and lower byte strobes. It maps a 1 MB window of dynamic memory onto that bus as two banks of 256K 16-bit words, and turns each bus cycle into a row strobe, a column strobe and a ready signal. The 9-bit memory address bus carries the row first, then the column. Everything runs from the single processor clock. There are no delay lines, and every access costs a fixed number of clocks.

A free-running interval counter raises a refresh request. The request is served at the first clock the controller is idle, which includes cycles where the bus is talking to some other resource. In that case the refresh is hidden from the processor. If the request is still open when a memory access arrives, the controller first runs a refresh on both banks, then serves the access, and the processor waits. Refresh rows come from a 9-bit counter that steps once per refresh.

Top module: `xmem_dram_ctrl`

## Requirements
- R1: The block responds only when address bit 23 is 0, bits 22..20 equal 3'b100 (byte addresses 0x400000 to 0x4FFFFF), and at least one byte strobe is low. For any other address no bank is opened for an access, neither CAS goes low and `rdy_n` stays high.
- R2: Address bit 19 picks the bank: 0 drives `ras_n[0]` low and 1 drives `ras_n[1]` low. Exactly one RAS is low while either CAS is low.
- R3: On the first clock of an access `ma` carries address bits 9..1 (the row). While CAS is low, `ma` carries bits 18..10 (the column).
- R4: `uds_n` low enables `ucas_n` and `lds_n` low enables `lcas_n`, so an unselected byte lane sees no CAS. `we_n` is low during CAS only when `rd_wr` is 0 (write).
- R5: With no refresh pending, RAS falls on the first rising edge that samples `as_n` low, CAS falls on the second, and `rdy_n` falls on the third. `rdy_n` never falls unless a CAS was low on the clock before.
- R6: On the clock after `as_n` is sampled high, `rdy_n`, both CAS and both RAS are high.
- R7: A refresh holds both RAS low together for exactly two clocks, with both CAS high and the refresh row on `ma`.
- R8: The refresh row starts at 0 after reset, steps by one per refresh and wraps modulo 512.
- R9: A pending refresh is carried out while the bus addresses a resource outside the window, with no ready or CAS given.
- R10: If a refresh is pending when a selected access begins, the refresh runs before CAS, and `rdy_n` is delayed past the normal third clock.
- R11: Each RAS line stays high for at least two clocks between any two activations, whether the next activation is an access or a refresh.
- R12: The interval times 512 rows must fit within the retention budget; elaboration rejects parameters that break this. With short bus cycles, the gap between refresh starts stays within three intervals.
- R13: While reset is held, both RAS, both CAS, `we_n` and `rdy_n` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper byte strobe, active low |
| lds_n | input | 1 | Lower byte strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 23 | Word address, bits 23..1 |
| ma | output | 9 | Multiplexed DRAM address |
| ras_n | output | 2 | Row strobe per bank, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| rdy_n | output | 1 | Bus ready to the processor, active low |

## Verification
The bench holds a selected access open across a full refresh interval, so the request matures while the controller is busy. It then starts the next access on the clock right after release. A controller that let the processor through without serving the overdue refresh would show CAS with no refresh ahead of it. A controller that restarted too soon would break the two-clock precharge on a bank.

A long cycle to a foreign address must absorb a refresh without any ready or CAS. A decoder that ignored bit 23 or the upper window bits would open a bank there. The refresh row is followed through more than 512 refreshes, so a counter of the wrong width, or one that skipped a step, shows up at the wrap.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   typedef enum logic [2:0] {
      XS_IDLE,
      XS_ROW,
      XS_CAS,
      XS_HOLD,
      XS_PRE,
      XS_RF1,
      XS_RF2
   } xs_state_e;
endpackage

// File: rtl/xmem_addr_decode.sv
module xmem_addr_decode #(
   parameter int         AW    = 23,
   parameter int         ROW_W = 9,
   parameter logic [2:0] WIN   = 3'b100
) (
   input  logic [AW:1]      addr,
   input  logic             uds_n,
   input  logic             lds_n,
   output logic             hit,
   output logic             bank,
   output logic [ROW_W-1:0] row,
   output logic [ROW_W-1:0] col
);
   localparam int BANK_IDX = 2*ROW_W + 1;

   generate
      if (AW != 2*ROW_W + 5) begin : g_bad_aw
         $error("xmem_addr_decode: AW must equal 2*ROW_W+5");
      end
   endgenerate

   // row from the low word-address bits, column from the next group up
   assign row  = addr[ROW_W:1];
   assign col  = addr[2*ROW_W:ROW_W+1];
   assign bank = addr[BANK_IDX];
   assign hit  = !addr[AW] && (addr[AW-1:AW-3] == WIN) && (!uds_n || !lds_n);
endmodule

// File: rtl/xmem_refresh.sv
module xmem_refresh #(
   parameter int INTERVAL       = 3000,
   parameter int ROW_W          = 9,
   parameter int RETENTION_CLKS = 1600000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   output logic             pend,
   output logic [ROW_W-1:0] rf_row
);
   localparam int            CW   = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
   localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

   generate
      if (INTERVAL < 2 || INTERVAL * (2**ROW_W) > RETENTION_CLKS) begin : g_bad_ivl
         $error("xmem_refresh: refresh interval too long for the row count");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          tick;

   assign tick = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         pend   <= 1'b0;
         rf_row <= '0;
      end else begin
         cnt <= tick ? '0 : cnt + 1'b1;
         if (tick)      pend <= 1'b1;
         else if (done) pend <= 1'b0;
         if (done) rf_row <= rf_row + 1'b1;
      end
   end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
   import xmem_pkg::*;
#(
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          as_n,
   input  logic          hit,
   input  logic          bank,
   input  logic          uds_n,
   input  logic          lds_n,
   input  logic          rd_wr,
   input  logic          pend,
   output logic [NB-1:0] ras_n,
   output logic          ucas_n,
   output logic          lcas_n,
   output logic          we_n,
   output logic          rdy_n,
   output logic          col_sel,
   output logic          rf_cyc,
   output logic          rf_done
);
   xs_state_e st, st_nx;
   logic      bank_q, ub_q, lb_q, wr_q;
   logic      row_open, cas_on;

   generate
      if (NB != 2) begin : g_bad_nb
         $error("xmem_seq: bank select decodes exactly two banks");
      end
   endgenerate

   always_comb begin
      st_nx = st;
      unique case (st)
         XS_IDLE: if (pend)               st_nx = XS_RF1;
                  else if (!as_n && hit)  st_nx = XS_ROW;
         XS_ROW:  st_nx = XS_CAS;
         XS_CAS:  st_nx = XS_HOLD;
         XS_HOLD: if (as_n)               st_nx = XS_PRE;
         XS_PRE:  st_nx = XS_IDLE;
         XS_RF1:  st_nx = XS_RF2;
         XS_RF2:  st_nx = XS_PRE;
         default: st_nx = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= XS_IDLE;
         bank_q <= 1'b0;
         ub_q   <= 1'b0;
         lb_q   <= 1'b0;
         wr_q   <= 1'b0;
      end else begin
         st <= st_nx;
         if (st == XS_IDLE && st_nx == XS_ROW) begin
            bank_q <= bank;
            ub_q   <= !uds_n;
            lb_q   <= !lds_n;
            wr_q   <= !rd_wr;
         end
      end
   end

   assign row_open = (st == XS_ROW) || (st == XS_CAS) || (st == XS_HOLD);
   assign cas_on   = (st == XS_CAS) || (st == XS_HOLD);
   assign rf_cyc   = (st == XS_RF1) || (st == XS_RF2);
   assign rf_done  = (st == XS_RF2);
   assign col_sel  = cas_on;
   assign ucas_n   = !(cas_on && ub_q);
   assign lcas_n   = !(cas_on && lb_q);
   assign we_n     = !(cas_on && wr_q);
   assign rdy_n    = !(st == XS_HOLD && !as_n);

   for (genvar b = 0; b < NB; b++) begin : g_ras
      assign ras_n[b] = !(rf_cyc || (row_open && (bank_q == 1'(b))));

      // R11
      precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ras_n[b]) |-> $past(ras_n[b], 2));
   end

   // R7
   refresh_cas_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n == '0) |-> (ucas_n && lcas_n));

   // R2
   one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ucas_n || !lcas_n) |-> ($countones(~ras_n) == 1));

   // R5
   rdy_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_n) |-> $past(!ucas_n || !lcas_n));

   // R6
   rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(as_n) |=> rdy_n);
endmodule

// File: rtl/xmem_dram_ctrl.sv
module xmem_dram_ctrl #(
   parameter int         AW             = 23,
   parameter int         ROW_W          = 9,
   parameter logic [2:0] WIN            = 3'b100,
   parameter int         REF_INTERVAL   = 3000,
   parameter int         RETENTION_CLKS = 1600000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             as_n,
   input  logic             uds_n,
   input  logic             lds_n,
   input  logic             rd_wr,
   input  logic [AW:1]      addr,
   output logic [ROW_W-1:0] ma,
   output logic [1:0]       ras_n,
   output logic             ucas_n,
   output logic             lcas_n,
   output logic             we_n,
   output logic             rdy_n
);
   localparam int NB = 2;

   logic             hit, bank, pend, col_sel, rf_cyc, rf_done;
   logic [ROW_W-1:0] row, col, rf_row;

   xmem_addr_decode #(.AW(AW), .ROW_W(ROW_W), .WIN(WIN)) i_dec (
      .addr  (addr),
      .uds_n (uds_n),
      .lds_n (lds_n),
      .hit   (hit),
      .bank  (bank),
      .row   (row),
      .col   (col)
   );

   xmem_refresh #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W),
                  .RETENTION_CLKS(RETENTION_CLKS)) i_rfr (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (rf_done),
      .pend   (pend),
      .rf_row (rf_row)
   );

   xmem_seq #(.NB(NB)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .as_n    (as_n),
      .hit     (hit),
      .bank    (bank),
      .uds_n   (uds_n),
      .lds_n   (lds_n),
      .rd_wr   (rd_wr),
      .pend    (pend),
      .ras_n   (ras_n),
      .ucas_n  (ucas_n),
      .lcas_n  (lcas_n),
      .we_n    (we_n),
      .rdy_n   (rdy_n),
      .col_sel (col_sel),
      .rf_cyc  (rf_cyc),
      .rf_done (rf_done)
   );

   // refresh row overrides the access address; column follows row after RAS
   assign ma = rf_cyc ? rf_row : (col_sel ? col : row);
endmodule

// File: tb/test_xmem_dram_ctrl.sv
`timescale 1ns/1ps
module test_xmem_dram_ctrl;
   localparam int INTERVAL = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rd_wr = 1'b1;
   logic [23:1] addr = '0;
   logic [8:0]  ma;
   logic [1:0]  ras_n;
   logic        ucas_n, lcas_n, we_n, rdy_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   xmem_dram_ctrl #(.REF_INTERVAL(INTERVAL)) i_xmem_dram_ctrl (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
      .rd_wr(rd_wr), .addr(addr), .ma(ma), .ras_n(ras_n), .ucas_n(ucas_n),
      .lcas_n(lcas_n), .we_n(we_n), .rdy_n(rdy_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // refresh and precharge monitor
   int         n_ref = 0, gap = 0, rf_len = 0;
   int         hi_cnt [2] = '{2, 2};
   logic [8:0] exp_rrow = 9'd0, last_rrow = 9'd0;
   logic       prev_both = 1'b0, both_now;
   logic [1:0] prev_ras = 2'b11;

   always @(negedge clk) begin
      if (rst_n) begin
         both_now = (ras_n == 2'b00);
         if (both_now && !prev_both) begin
            n_ref++;
            if (n_ref > 1) chk(gap <= 3*INTERVAL, "R12 refresh gap", gap, 3*INTERVAL);
            chk(ma == exp_rrow, "R8 refresh row", ma, exp_rrow);
            last_rrow = ma;
            exp_rrow  = ma + 9'd1;
            gap    = 0;
            rf_len = 0;
         end
         if (both_now) begin
            rf_len++;
            if (!(ucas_n && lcas_n)) chk(0, "R7 cas during refresh", 0, 1);
         end
         if (!both_now && prev_both) chk(rf_len == 2, "R7 refresh length", rf_len, 2);
         gap++;
         for (int b = 0; b < 2; b++) begin
            if (prev_ras[b] && !ras_n[b]) chk(hi_cnt[b] >= 2, "R11 precharge", hi_cnt[b], 2);
            if (ras_n[b]) hi_cnt[b]++;
            else          hi_cnt[b] = 0;
         end
         prev_both = both_now;
         prev_ras  = ras_n;
      end
   end

   task automatic sync_idle();
      int k = n_ref;
      while (n_ref == k) @(posedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic do_access(input logic [23:0] a, input bit u, input bit l,
                            input bit wr, input int hold, input bit fast);
      int   row_k = 0, cas_k = 0, rdy_k = 0;
      bit   saw_ref = 0, uc = 0, lc = 0, we = 0, bnk = 0;
      logic [8:0] row_ma = '0, col_ma = '0;
      addr  = a[23:1];
      uds_n = !u;
      lds_n = !l;
      rd_wr = !wr;
      as_n  = 1'b0;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (ras_n == 2'b00 && cas_k == 0) saw_ref = 1;
         if (row_k == 0 && (ras_n == 2'b01 || ras_n == 2'b10)) begin
            row_k = k; row_ma = ma; bnk = (ras_n == 2'b01);
         end
         if (cas_k == 0 && (!ucas_n || !lcas_n)) begin
            cas_k = k; col_ma = ma; uc = !ucas_n; lc = !lcas_n; we = !we_n;
         end
         if (!rdy_n) begin
            rdy_k = k;
            break;
         end
      end
      chk(bnk == a[19], "R2 bank", bnk, a[19]);
      chk(row_ma == a[9:1], "R3 row address", row_ma, a[9:1]);
      chk(col_ma == a[18:10], "R3 column address", col_ma, a[18:10]);
      chk(uc == u, "R4 upper cas", uc, u);
      chk(lc == l, "R4 lower cas", lc, l);
      chk(we == wr, "R4 write enable", we, wr);
      if (fast) begin
         chk(row_k == 1, "R5 ras clock", row_k, 1);
         chk(cas_k == 2, "R5 cas clock", cas_k, 2);
         chk(rdy_k == 3, "R5 ready clock", rdy_k, 3);
      end else begin
         chk(saw_ref, "R10 refresh before cas", saw_ref, 1);
         chk(rdy_k > 3, "R10 ready delayed", rdy_k, 4);
      end
      repeat (hold) @(negedge clk);
      as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rd_wr = 1'b1;
      @(negedge clk);
      chk(rdy_n && ucas_n && lcas_n && ras_n == 2'b11, "R6 release",
          {rdy_n, ucas_n, lcas_n, ras_n}, 5'b11111);
   endtask

   task automatic t_accesses();
      sync_idle();
      do_access(24'h45A6B4, 1, 1, 0, 2, 1);   // word read, bank 0
      sync_idle();
      do_access(24'h4CF3E2, 1, 0, 1, 1, 1);   // upper byte write, bank 1
      sync_idle();
      do_access(24'h4803FE, 0, 1, 1, 0, 1);   // lower byte write, bank 1
   endtask

   task automatic foreign(input logic [23:0] a, input int cycles, input bit want_ref);
      int k = n_ref;
      bit bad = 0;
      addr = a[23:1]; lds_n = 1'b0; as_n = 1'b0;
      repeat (cycles) begin
         @(negedge clk);
         if (!ucas_n || !lcas_n || !rdy_n || ras_n == 2'b01 || ras_n == 2'b10) bad = 1;
      end
      chk(!bad, "R1 foreign address ignored", bad, 0);
      if (want_ref) chk(n_ref > k, "R9 hidden refresh", n_ref - k, 1);
      as_n = 1'b1; lds_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_foreign();
      sync_idle();
      foreign(24'h2A0010, INTERVAL + 5, 1);
      sync_idle();
      foreign(24'hC01234, 6, 0);
      sync_idle();
      foreign(24'h501234, 6, 0);
   endtask

   task automatic t_forced();
      sync_idle();
      do_access(24'h412340, 0, 1, 1, INTERVAL + 5, 1);
      do_access(24'h4ABCDE, 1, 1, 0, 1, 0);
   endtask

   task automatic t_row_wrap();
      while (n_ref < 513) @(posedge clk);
      @(negedge clk);
      chk(last_rrow == 9'd0, "R8 row wrap", last_rrow, 0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(ras_n == 2'b11 && ucas_n && lcas_n && we_n && rdy_n, "R13 reset outputs",
          {ras_n, ucas_n, lcas_n, we_n, rdy_n}, 6'b111111);
      rst_n = 1'b1;
      t_accesses();
      t_foreign();
      t_forced();
      t_row_wrap();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         summary();
         $finish;
      end
   end
endmodule